// File: doc/BRIEF.md
# Event Header and Trailer Framer

The framer turns one event's payload into a complete, self-describing block of 32-bit words on an output stream. A producer presents the event's descriptive fields together with a one-cycle start pulse. It then streams the payload words, marking the final one. The block holds the payload internally until the whole event is present, because the header must state the event's length before any payload word leaves.

Once the payload is complete, the framer sends the event as follows:
- an opening control word;
- three header words;
- the stored payload, in arrival order;
- a closing control word.

The size field counts every word of the event except the two control words. That is the payload length plus the three header words. The output uses a valid/ready handshake, and the framer holds a word steady for as long as the consumer stalls. One event is handled at a time. The block is idle again after the closing word is taken.

Top module: `evt_framer`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are 0 and `evt_idle` is 1.
- R2: A start pulse is taken only while `evt_idle` is 1, and `evt_idle` drops on the next cycle. A start pulse, or changed descriptive fields, seen while an event is in progress does not alter that event's header.
- R3: Payload words are accepted (`in_valid` and `in_ready` both 1) only between an accepted start and the word marked by `in_last`. `in_ready` is 0 while idle, while the event is being sent, and whenever the internal store holds DEPTH words. An event carries 1 to DEPTH payload words.
- R4: The first output word of an event is 0x00000000 with `out_ctrl` = 1.
- R5: The second word has bit 31 = 0, the event type in bits 30:26, the source ID in bits 25:16, and the size in bits 15:0, with `out_ctrl` = 0. The size equals the payload word count plus 3.
- R6: The third word has bit 31 = 0, the spill number in bits 30:20 and the event number in bits 19:0, with `out_ctrl` = 0.
- R7: The fourth word has the format version in bits 31:24, the error-word count in bits 23:16, the trigger-system error byte in bits 15:8 and the status byte in bits 7:0, with `out_ctrl` = 0.
- R8: The payload words follow, each exactly once, in arrival order, with `out_ctrl` = 0. Under any pattern of `out_ready`, the event is exactly payload + 5 words long.
- R9: The last word of an event is 0xCFED1200 with `out_ctrl` = 1.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output is held: `out_valid`, `out_data` and `out_ctrl` stay unchanged on the next cycle.
- R11: After the closing word is accepted, the block returns to idle (`evt_idle` = 1, `out_valid` = 0) and can take a new start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_start | input | 1 | One-cycle pulse that opens an event and captures the descriptive fields |
| evt_kind | input | 5 | Event type |
| evt_src | input | 10 | Source ID |
| evt_spill | input | 11 | Spill number |
| evt_num | input | 20 | Event number |
| evt_fmt | input | 8 | Format version |
| evt_errw | input | 8 | Error-word count |
| evt_trgerr | input | 8 | Trigger-system error byte |
| evt_stat | input | 8 | Status byte |
| evt_idle | output | 1 | High when no event is open and a start pulse will be taken |
| in_valid | input | 1 | Payload word valid |
| in_data | input | 32 | Payload word |
| in_last | input | 1 | Marks the final payload word of the event |
| in_ready | output | 1 | Payload word can be accepted |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Output word |
| out_ctrl | output | 1 | Marks the opening and closing control words |

## Verification
The assertions take three things for granted about the producer:
- no event carries more than DEPTH payload words;
- every event's payload ends with a word marked `in_last`;
- the start pulse arrives before the event's payload.

If the first or second assumption is broken, the framer waits forever, which no property can tell apart from a slow producer. The stimulus keeps payload lengths between 1 and DEPTH on a small store. It always raises the last marker on the final word, and it pulses start only after the previous event's closing word has been taken. The single exception is a deliberate extra pulse in the middle of an event, which checks that such a pulse is ignored.

// File: rtl/evt_framer_pkg.sv
package evt_framer_pkg;

    localparam logic [31:0] OPEN_WORD  = 32'h0000_0000;
    localparam logic [31:0] CLOSE_WORD = 32'hCFED_1200;
    localparam int          HDR_WORDS  = 3;

    typedef struct packed {
        logic [4:0]  kind;
        logic [9:0]  src;
        logic [10:0] spill;
        logic [19:0] evnum;
        logic [7:0]  fmt;
        logic [7:0]  errw;
        logic [7:0]  trgerr;
        logic [7:0]  stat;
    } evt_meta_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_OPEN,
        ST_H1,
        ST_H2,
        ST_H3,
        ST_BODY,
        ST_CLOSE
    } fr_state_e;

    function automatic logic [31:0] pack_w1(evt_meta_t m, logic [15:0] size);
        return {1'b0, m.kind, m.src, size};
    endfunction

    function automatic logic [31:0] pack_w2(evt_meta_t m);
        return {1'b0, m.spill, m.evnum};
    endfunction

    function automatic logic [31:0] pack_w3(evt_meta_t m);
        return {m.fmt, m.errw, m.trgerr, m.stat};
    endfunction

endpackage

// File: rtl/evt_framer_fifo.sv
module evt_framer_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 1024
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + AW'(1);
            if (pop)  rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + AW'(1);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = mem[rd_q];
    assign count = cnt_q;
    assign full  = (cnt_q == FULL_CNT);

endmodule

// File: rtl/evt_framer_word_sel.sv
module evt_framer_word_sel
    import evt_framer_pkg::*;
(
    input  fr_state_e     state,
    input  evt_meta_t     meta,
    input  logic [15:0]   size,
    input  logic [31:0]   body_word,
    output logic [31:0]   word,
    output logic          ctrl
);
    always_comb begin
        word = '0;
        ctrl = 1'b0;
        case (state)
            ST_OPEN:  begin word = OPEN_WORD;           ctrl = 1'b1; end
            ST_H1:    word = pack_w1(meta, size);
            ST_H2:    word = pack_w2(meta);
            ST_H3:    word = pack_w3(meta);
            ST_BODY:  word = body_word;
            ST_CLOSE: begin word = CLOSE_WORD;          ctrl = 1'b1; end
            default:  begin word = '0;                  ctrl = 1'b0; end
        endcase
    end
endmodule

// File: rtl/evt_framer.sv
module evt_framer
    import evt_framer_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt_start,
    input  logic [4:0]   evt_kind,
    input  logic [9:0]   evt_src,
    input  logic [10:0]  evt_spill,
    input  logic [19:0]  evt_num,
    input  logic [7:0]   evt_fmt,
    input  logic [7:0]   evt_errw,
    input  logic [7:0]   evt_trgerr,
    input  logic [7:0]   evt_stat,
    output logic         evt_idle,
    input  logic         in_valid,
    input  logic [31:0]  in_data,
    input  logic         in_last,
    output logic         in_ready,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [31:0]  out_data,
    output logic         out_ctrl
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] ONE_LEFT = CW'(1);

    fr_state_e     state_q, state_d;
    evt_meta_t     meta_q;
    logic [CW-1:0] pcnt_q;
    logic [CW-1:0] fifo_count;
    logic          fifo_full;
    logic [31:0]   fifo_rdata;
    logic          push, pop, fire;
    logic [15:0]   size_w;

    assign evt_idle  = (state_q == ST_IDLE);
    assign in_ready  = (state_q == ST_FILL) && !fifo_full;
    assign push      = in_valid && in_ready;
    assign out_valid = (state_q != ST_IDLE) && (state_q != ST_FILL);
    assign fire      = out_valid && out_ready;
    assign pop       = fire && (state_q == ST_BODY);
    assign size_w    = 16'(pcnt_q) + 16'(HDR_WORDS);

    evt_framer_fifo #(.W(32), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .wdata (in_data),
        .pop   (pop),
        .rdata (fifo_rdata),
        .count (fifo_count),
        .full  (fifo_full)
    );

    evt_framer_word_sel u_sel (
        .state     (state_q),
        .meta      (meta_q),
        .size      (size_w),
        .body_word (fifo_rdata),
        .word      (out_data),
        .ctrl      (out_ctrl)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (evt_start)         state_d = ST_FILL;
            ST_FILL:  if (push && in_last)   state_d = ST_OPEN;
            ST_OPEN:  if (fire)              state_d = ST_H1;
            ST_H1:    if (fire)              state_d = ST_H2;
            ST_H2:    if (fire)              state_d = ST_H3;
            ST_H3:    if (fire)              state_d = ST_BODY;
            ST_BODY:  if (fire && fifo_count == ONE_LEFT) state_d = ST_CLOSE;
            ST_CLOSE: if (fire)              state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            meta_q  <= '0;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (evt_idle && evt_start) begin
                meta_q <= '{kind: evt_kind, src: evt_src, spill: evt_spill,
                            evnum: evt_num, fmt: evt_fmt, errw: evt_errw,
                            trgerr: evt_trgerr, stat: evt_stat};
                pcnt_q <= '0;
            end else if (push) begin
                pcnt_q <= pcnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/evt_framer_chk.sv
module evt_framer_chk #(
    parameter int DEPTH = 1024
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        evt_start,
    input logic                        evt_idle,
    input logic                        in_ready,
    input logic                        out_valid,
    input logic                        out_ready,
    input logic [31:0]                 out_data,
    input logic                        out_ctrl,
    input logic [$clog2(DEPTH+1)-1:0]  fifo_count
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        evt_idle |-> (!out_valid && !in_ready));

    p_start_taken_r2: assert property (@(posedge clk) disable iff (rst)
        (evt_idle && evt_start) |=> !evt_idle);

    p_full_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == FULL_CNT) |-> !in_ready);

    p_no_take_while_send_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_ctrl_value_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ctrl) |-> (out_data == 32'h0000_0000 || out_data == 32'hCFED_1200));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl)));

endmodule

bind evt_framer evt_framer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_start  (evt_start),
    .evt_idle   (evt_idle),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_ctrl   (out_ctrl),
    .fifo_count (fifo_count)
);

// File: tb/evt_framer_bench.sv
`timescale 1ns/1ps
module evt_framer_bench;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_start = 1'b0;
    logic [4:0]  evt_kind = '0;
    logic [9:0]  evt_src = '0;
    logic [10:0] evt_spill = '0;
    logic [19:0] evt_num = '0;
    logic [7:0]  evt_fmt = '0, evt_errw = '0, evt_trgerr = '0, evt_stat = '0;
    logic        evt_idle;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_ctrl;

    int checks = 0;
    int errors = 0;

    logic [31:0] cap_d [0:31];
    logic        cap_c [0:31];

    always #2 clk = ~clk;

    evt_framer #(.DEPTH(DEPTH)) u_evt_framer (
        .clk(clk), .rst(rst), .evt_start(evt_start),
        .evt_kind(evt_kind), .evt_src(evt_src), .evt_spill(evt_spill),
        .evt_num(evt_num), .evt_fmt(evt_fmt), .evt_errw(evt_errw),
        .evt_trgerr(evt_trgerr), .evt_stat(evt_stat), .evt_idle(evt_idle),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_ctrl(out_ctrl)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete actual=%h expected=%h", 0, 1);
        finish_run();
    end

    function automatic logic [4:0]  f_kind(int e);   return 5'(31 - e * 7);        endfunction
    function automatic logic [9:0]  f_src(int e);    return 10'(1023 - e * 13);    endfunction
    function automatic logic [10:0] f_spill(int e);  return 11'(2047 - e * 5);     endfunction
    function automatic logic [19:0] f_num(int e);    return 20'(1048575 - e * 999); endfunction
    function automatic logic [7:0]  f_fmt(int e);    return 8'(e + 1);             endfunction
    function automatic logic [7:0]  f_errw(int e);   return 8'(255 - e);           endfunction
    function automatic logic [7:0]  f_trg(int e);    return 8'(e * 3);             endfunction
    function automatic logic [7:0]  f_stat(int e);   return 8'(e) ^ 8'hA5;         endfunction
    function automatic logic [31:0] f_pay(int e, int i);
        return 32'h00C0_FFEE + 32'(e) * 32'h0100_0000 + 32'(i) * 32'h0001_1001;
    endfunction

    task automatic drive_meta(input int e);
        evt_kind   = f_kind(e);
        evt_src    = f_src(e);
        evt_spill  = f_spill(e);
        evt_num    = f_num(e);
        evt_fmt    = f_fmt(e);
        evt_errw   = f_errw(e);
        evt_trgerr = f_trg(e);
        evt_stat   = f_stat(e);
    endtask

    task automatic run_event(input int e, input int len, input int mode, input bit poke);
        int idx = 0;
        int ncap = 0;
        int cyc = 0;
        bit done = 0;
        bit stalled = 0;
        bit seen_out = 0;
        logic [31:0] prev_d = '0;
        logic        prev_c = 1'b0;
        logic [31:0] exp_w;

        @(negedge clk);
        drive_meta(e);
        evt_start = 1'b1;
        @(negedge clk);
        evt_start = 1'b0;
        check(evt_idle == 1'b0, "R2 start taken while idle", 32'(evt_idle), 32'h0);

        while (!done && cyc < 600) begin
            in_valid  = (idx < len) && (mode == 0 || cyc % 2 == 0);
            in_data   = f_pay(e, idx);
            in_last   = (idx == len - 1);
            out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 2 == 1) : (cyc % 3 != 0);
            if (poke && cyc == 1) begin
                drive_meta(e + 77);
                evt_start = 1'b1;
            end else begin
                evt_start = 1'b0;
            end
            #1;
            if (stalled) begin
                check(out_valid && out_data == prev_d && out_ctrl == prev_c,
                      "R10 held under stall", out_data, prev_d);
            end
            if (out_valid && !seen_out) begin
                seen_out = 1;
                check(in_ready == 1'b0, "R3 no payload taken while sending", 32'(in_ready), 32'h0);
            end
            if (in_valid && in_ready) idx++;
            if (out_valid && out_ready) begin
                if (ncap < 32) begin
                    cap_d[ncap] = out_data;
                    cap_c[ncap] = out_ctrl;
                end
                ncap++;
                if (out_ctrl && ncap > 1) done = 1;
            end
            stalled = out_valid && !out_ready;
            prev_d  = out_data;
            prev_c  = out_ctrl;
            @(negedge clk);
            cyc++;
        end
        in_valid  = 1'b0;
        in_last   = 1'b0;
        out_ready = 1'b0;
        evt_start = 1'b0;

        check(ncap == len + 5, "R8 event word count", 32'(ncap), 32'(len + 5));
        if (ncap == len + 5) begin
            check(cap_d[0] == 32'h0 && cap_c[0], "R4 opening control word", cap_d[0], 32'h0);
            exp_w = {1'b0, f_kind(e), f_src(e), 16'(len + 3)};
            check(cap_d[1] == exp_w && !cap_c[1], "R5 header word one", cap_d[1], exp_w);
            exp_w = {1'b0, f_spill(e), f_num(e)};
            check(cap_d[2] == exp_w && !cap_c[2], "R6 header word two", cap_d[2], exp_w);
            exp_w = {f_fmt(e), f_errw(e), f_trg(e), f_stat(e)};
            check(cap_d[3] == exp_w && !cap_c[3], "R7 header word three", cap_d[3], exp_w);
            for (int i = 0; i < len; i++) begin
                check(cap_d[4 + i] == f_pay(e, i) && !cap_c[4 + i], "R8 payload order",
                      cap_d[4 + i], f_pay(e, i));
            end
            check(cap_d[len + 4] == 32'hCFED_1200 && cap_c[len + 4], "R9 closing word",
                  cap_d[len + 4], 32'hCFED_1200);
        end
        #1;
        check(evt_idle && !out_valid, "R11 back to idle", {30'h0, evt_idle, out_valid}, 32'h2);
    endtask

    initial begin
        int ev = 0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 32'h0);
        check(in_ready == 1'b0, "R1 reset in_ready", 32'(in_ready), 32'h0);
        check(evt_idle == 1'b1, "R1 reset idle", 32'(evt_idle), 32'h1);
        rst = 1'b0;

        // R3: payload offered before any start is refused and nothing is sent
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'hDEAD_BEEF;
        in_last  = 1'b1;
        out_ready = 1'b1;
        repeat (3) begin
            @(negedge clk);
            #1;
            check(in_ready == 1'b0 && out_valid == 1'b0, "R3 refused while idle",
                  {30'h0, in_ready, out_valid}, 32'h0);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;

        for (int len = 1; len <= DEPTH; len++) begin
            for (int mode = 0; mode < 3; mode++) begin
                run_event(ev, len, mode, (len % 3 == 0));
                ev++;
            end
        end
        finish_run();
    end
endmodule